// File: doc/BRIEF.md
# Indexed Block-Access Register Slave for a Clock Fan-Out Buffer

This block is a two-wire management slave that holds the seven configuration bytes of a differential clock fan-out buffer. A host sets a starting index and then either streams a counted block of bytes into consecutive registers, or, after a repeated start in the read direction, pulls out a length byte followed by consecutive register contents. Every register is also exported in parallel, so the clock datapath sees the current settings without any further decoding.

The two bus lines come in as plain inputs, sampled on the system clock through synchronisers. The slave drives the data line only through a pull-down enable, and it never holds the clock line. The system clock must run at least eight times faster than SCL. The register contents are:

- **Index 0, configuration.** Bit 7 selects the power-down output mode and bit 6 selects the stop output mode. Bit 2 selects low loop bandwidth, bit 1 selects PLL (zero-delay) mode, and bit 0 selects an undivided output. Bits 5..3 always read 0.
- **Index 1, per-channel output enable.** Bit n controls channel n.
- **Index 2, per-channel stoppable select.** Bit n controls channel n.
- **Index 3, spare byte.**
- **Index 4, fixed identity byte.**
- **Index 5, device identity byte.** This byte is writable.
- **Index 6, read-back length byte.**

Top module: `clkbuf_mgmt_slave`

## Requirements
- R1: After reset the outputs read cfg_o=0x07, chan_en_o=0xFF, stop_sel_o=0x00, spare_o=0x00, rev_vendor_o=0x01, dev_id_o=0x08 and rd_len_o=0x05, and sda_pd_o is 0.
- R2: The 8-bit address byte 0xDC (write) and 0xDD (read) is acknowledged. Any other address byte is not acknowledged, and every byte that follows it, up to the next start, is ignored with no acknowledge.
- R3: A write sequence stores X data bytes at indices N through N+X-1 and acknowledges every byte. The sequence is: start, 0xDC, index N, count X, the data bytes, stop.
- R4: Data bytes beyond the count X are acknowledged and discarded.
- R5: A read sequence returns first the byte at index 6, then the bytes at indices N, N+1, and so on, for as long as the host acknowledges. The sequence is: start, 0xDC, index N, repeated start, 0xDD.
- R6: Index 4 always reads 0x01, and writes to it are discarded. Bits 5..3 of index 0 always read 0, and writes to them are discarded.
- R7: Writes to indices 7 and above are acknowledged and discarded. Reads of indices 7 and above return 0x00.
- R8: The slave pulls SDA low only during the ninth clock of a byte it acknowledges, and while sending a 0 bit in a read. It releases SDA once the host answers a read byte with a not-acknowledge.
- R9: A start or a stop inside a byte discards the partial byte. A stop returns the slave to idle. A start begins a new address phase, and the index already set is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pd_o | output | 1 | Pull-down enable for the data line |
| cfg_o | output | 8 | Index 0: mode and selection bits |
| chan_en_o | output | 8 | Index 1: output enable per channel |
| stop_sel_o | output | 8 | Index 2: stoppable select per channel |
| spare_o | output | 8 | Index 3: spare byte |
| rev_vendor_o | output | 8 | Index 4: fixed identity byte |
| dev_id_o | output | 8 | Index 5: device identity byte |
| rd_len_o | output | 8 | Index 6: read-back length byte |

## Verification
Every bus edge reaches the control logic 2 system clocks late through the synchroniser, and the event is acted on at the third clock edge. So an acknowledge or a read bit appears on sda_pd_o 3 clocks after the SCL fall that starts it. A stored byte appears on its output port 4 clocks after the eighth SCL rise of that byte. The bench moves SCL and SDA only on falling system-clock edges, and it holds each quarter of an SCL period for 4 system clocks. It samples the bus in the middle of each high phase, 4 clocks after the rise, when the slave's response is already settled. It compares the parallel outputs only after the stop, against a byte model that applies the write masks arithmetically.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 7;

  typedef enum logic [2:0] {
    M_IDLE,
    M_RX,
    M_ACK,
    M_TX,
    M_HACK
  } mode_e;

  typedef enum logic [1:0] {
    R_ADDR,
    R_INDEX,
    R_COUNT,
    R_DATA
  } role_e;

  // Reset contents of each register index.
  function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      4:       return 8'h01;
      5:       return 8'h08;
      6:       return 8'h05;
      default: return 8'h00;
    endcase
  endfunction

  // Writable bits of each register index.
  function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
    case (idx)
      0:       return 8'hC7;
      4:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/smbreg_sync.sv
module smbreg_sync #(
  parameter int         WIDTH   = 2,
  parameter int         STAGES  = 2,
  parameter logic [0:0] RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= {WIDTH{RST_VAL}};
    else     stg_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[g] <= {WIDTH{RST_VAL}};
      else     stg_q[g] <= stg_q[g-1];
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/smbreg_events.sv
module smbreg_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  // R9: bus events are mutually exclusive, so start/stop abort cleanly
  assert_events_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall, start_ev, stop_ev}));

endmodule

// File: rtl/smbreg_link.sv
module smbreg_link
  import smbreg_pkg::*;
#(
  parameter int                WIDTH   = 8,
  parameter logic [WIDTH-1:0]  WR_ADDR = 8'hDC,
  parameter logic [WIDTH-1:0]  RD_ADDR = 8'hDD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             sda_s,
  input  logic [WIDTH-1:0] rd_data_i,
  input  logic [WIDTH-1:0] rd_len_i,
  output logic             sda_pd_o,
  output logic             wr_en_o,
  output logic [WIDTH-1:0] wr_idx_o,
  output logic [WIDTH-1:0] wr_data_o,
  output logic [WIDTH-1:0] rd_idx_o
);

  localparam int             CNT_W    = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  mode_e            mode_q;
  role_e            role_q;
  logic [CNT_W-1:0] bit_q;
  logic [WIDTH-1:0] sh_q;
  logic [WIDTH-1:0] idx_q;
  logic [WIDTH-1:0] left_q;
  logic             full_q, ack_ok_q, rd_dir_q, tx_first_q, host_ack_q;

  logic [WIDTH-1:0] rx_byte;
  logic [WIDTH-1:0] tx_byte;

  assign rx_byte  = {sh_q[WIDTH-2:0], sda_s};
  assign tx_byte  = tx_first_q ? rd_len_i : rd_data_i;
  assign rd_idx_o = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_IDLE;
      role_q     <= R_ADDR;
      bit_q      <= '0;
      sh_q       <= '0;
      idx_q      <= '0;
      left_q     <= '0;
      full_q     <= 1'b0;
      ack_ok_q   <= 1'b0;
      rd_dir_q   <= 1'b0;
      tx_first_q <= 1'b0;
      host_ack_q <= 1'b0;
      sda_pd_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_ev) begin
        mode_q   <= M_RX;
        role_q   <= R_ADDR;
        bit_q    <= '0;
        full_q   <= 1'b0;
        sda_pd_o <= 1'b0;
      end else if (stop_ev) begin
        mode_q   <= M_IDLE;
        full_q   <= 1'b0;
        sda_pd_o <= 1'b0;
      end else begin
        case (mode_q)
          M_RX: begin
            if (scl_rise && !full_q) begin
              sh_q  <= rx_byte;
              bit_q <= bit_q + 1'b1;
              if (bit_q == LAST_BIT) begin
                full_q   <= 1'b1;
                ack_ok_q <= 1'b1;
                case (role_q)
                  R_ADDR: begin
                    ack_ok_q   <= (rx_byte == WR_ADDR) || (rx_byte == RD_ADDR);
                    rd_dir_q   <= (rx_byte == RD_ADDR);
                    tx_first_q <= 1'b1;
                  end
                  R_INDEX: idx_q  <= rx_byte;
                  R_COUNT: left_q <= rx_byte;
                  default: begin
                    if (left_q != '0) begin
                      wr_en_o   <= 1'b1;
                      wr_idx_o  <= idx_q;
                      wr_data_o <= rx_byte;
                      idx_q     <= idx_q + 1'b1;
                      left_q    <= left_q - 1'b1;
                    end
                  end
                endcase
              end
            end else if (scl_fall && full_q) begin
              full_q <= 1'b0;
              if (ack_ok_q) begin
                mode_q   <= M_ACK;
                sda_pd_o <= 1'b1;
              end else begin
                mode_q <= M_IDLE;
              end
            end
          end
          M_ACK: begin
            if (scl_fall) begin
              if (role_q == R_ADDR && rd_dir_q) begin
                mode_q     <= M_TX;
                sh_q       <= tx_byte;
                sda_pd_o   <= ~tx_byte[WIDTH-1];
                bit_q      <= '0;
                tx_first_q <= 1'b0;
                if (!tx_first_q) idx_q <= idx_q + 1'b1;
              end else begin
                mode_q   <= M_RX;
                sda_pd_o <= 1'b0;
                bit_q    <= '0;
                case (role_q)
                  R_ADDR:  role_q <= R_INDEX;
                  R_INDEX: role_q <= R_COUNT;
                  default: role_q <= R_DATA;
                endcase
              end
            end
          end
          M_TX: begin
            if (scl_fall) begin
              if (bit_q == LAST_BIT) begin
                sda_pd_o <= 1'b0;
                mode_q   <= M_HACK;
              end else begin
                sh_q     <= {sh_q[WIDTH-2:0], 1'b0};
                sda_pd_o <= ~sh_q[WIDTH-2];
                bit_q    <= bit_q + 1'b1;
              end
            end
          end
          M_HACK: begin
            if (scl_rise) begin
              host_ack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack_q) begin
                mode_q     <= M_TX;
                sh_q       <= tx_byte;
                sda_pd_o   <= ~tx_byte[WIDTH-1];
                bit_q      <= '0;
                tx_first_q <= 1'b0;
                if (!tx_first_q) idx_q <= idx_q + 1'b1;
              end else begin
                mode_q <= M_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: a stop always returns the slave to idle with SDA released
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (mode_q == M_IDLE) && !sda_pd_o);

  // R8: the pull-down only changes on an SCL fall (or a bus abort)
  assert_pd_low_phase_R8: assert property (@(posedge clk) disable iff (rst)
    (sda_pd_o != $past(sda_pd_o)) && !$past(start_ev) && !$past(stop_ev)
      |-> $past(scl_fall));

  // R2: a rejected address leaves the bus alone until the next start
  assert_nack_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_RX) && full_q && !ack_ok_q && scl_fall && !start_ev && !stop_ev
      |=> (mode_q == M_IDLE) && !sda_pd_o);

  // R4: a store only happens while the byte count has not run out
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> ($past(left_q) != '0) && (left_q == $past(left_q) - 1'b1));

  // R3: stores only occur in the write direction
  assert_write_dir_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> !rd_dir_q);

endmodule

// File: rtl/smbreg_file.sv
module smbreg_file
  import smbreg_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int WIDTH = BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_i,
  input  logic [WIDTH-1:0]            wr_idx_i,
  input  logic [WIDTH-1:0]            wr_data_i,
  input  logic [WIDTH-1:0]            rd_idx_i,
  output logic [WIDTH-1:0]            rd_data_o,
  output logic [NREGS-1:0][WIDTH-1:0] bank_o
);

  logic [NREGS-1:0][WIDTH-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) bank_q[i] <= reg_reset(i);
    end else if (wr_en_i) begin
      for (int i = 0; i < NREGS; i++) begin
        if (wr_idx_i == WIDTH'(i))
          bank_q[i] <= (bank_q[i] & ~reg_wmask(i)) | (wr_data_i & reg_wmask(i));
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_idx_i == WIDTH'(i)) rd_data_o = bank_q[i];
    end
  end

  assign bank_o = bank_q;

  // R7: stores aimed past the last index leave every register untouched
  assert_oob_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en_i && (wr_idx_i >= WIDTH'(NREGS)) |=> $stable(bank_q));

endmodule

// File: rtl/clkbuf_mgmt_slave.sv
module clkbuf_mgmt_slave
  import smbreg_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  WR_ADDR     = 8'hDC,
  parameter logic [7:0]  RD_ADDR     = 8'hDD
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  output logic [7:0] cfg_o,
  output logic [7:0] chan_en_o,
  output logic [7:0] stop_sel_o,
  output logic [7:0] spare_o,
  output logic [7:0] rev_vendor_o,
  output logic [7:0] dev_id_o,
  output logic [7:0] rd_len_o
);

  logic [1:0]                     bus_s;
  logic                           scl_rise, scl_fall, start_ev, stop_ev;
  logic                           wr_en;
  logic [BYTE_W-1:0]              wr_idx, wr_data, rd_idx, rd_data;
  logic [NUM_REGS-1:0][BYTE_W-1:0] bank;

  smbreg_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .dout(bus_s)
  );

  smbreg_events u_events (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (bus_s[1]),
    .sda_s   (bus_s[0]),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  smbreg_link #(
    .WIDTH  (BYTE_W),
    .WR_ADDR(WR_ADDR),
    .RD_ADDR(RD_ADDR)
  ) u_link (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_s    (bus_s[0]),
    .rd_data_i(rd_data),
    .rd_len_i (bank[6]),
    .sda_pd_o (sda_pd_o),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_data_o(wr_data),
    .rd_idx_o (rd_idx)
  );

  smbreg_file #(
    .NREGS(NUM_REGS),
    .WIDTH(BYTE_W)
  ) u_file (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data),
    .bank_o   (bank)
  );

  assign cfg_o        = bank[0];
  assign chan_en_o    = bank[1];
  assign stop_sel_o   = bank[2];
  assign spare_o      = bank[3];
  assign rev_vendor_o = bank[4];
  assign dev_id_o     = bank[5];
  assign rd_len_o     = bank[6];

endmodule

// File: tb/clkbuf_mgmt_slave_tb.sv
module clkbuf_mgmt_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 4;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_pd_o;
  logic [7:0] cfg_o, chan_en_o, stop_sel_o, spare_o, rev_vendor_o, dev_id_o, rd_len_o;
  wire  sda_bus = sda_h & ~sda_pd_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit pd_bad  = 1'b0;
  logic [7:0] exp_q [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkbuf_mgmt_slave u_dut (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_h),
    .sda_i       (sda_bus),
    .sda_pd_o    (sda_pd_o),
    .cfg_o       (cfg_o),
    .chan_en_o   (chan_en_o),
    .stop_sel_o  (stop_sel_o),
    .spare_o     (spare_o),
    .rev_vendor_o(rev_vendor_o),
    .dev_id_o    (dev_id_o),
    .rd_len_o    (rd_len_o)
  );

  function automatic logic [7:0] mask_of(input int i);
    if (i == 0) return 8'hC7;
    if (i == 4 || i > 6) return 8'h00;
    return 8'hFF;
  endfunction

  task automatic model_write(input int i, input logic [7:0] d);
    if (i < 7) exp_q[i] = (exp_q[i] & ~mask_of(i)) | (d & mask_of(i));
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, expv);
    end
  endtask

  task automatic qw();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; qw();
    scl_h = 1'b1; qw();
    sda_h = 1'b0; qw();
    scl_h = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; qw();
    scl_h = 1'b1; qw();
    sda_h = 1'b1; qw(); qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; qw();
      scl_h = 1'b1; qw();
      if (sda_pd_o) pd_bad = 1'b1;
      qw();
      scl_h = 1'b0; qw();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    send_bits(b, 8);
    sda_h = 1'b1; qw();
    scl_h = 1'b1; qw();
    nak = sda_bus;
    qw();
    scl_h = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw();
      scl_h = 1'b1; qw();
      b[i] = sda_bus;
      qw();
      scl_h = 1'b0; qw();
    end
    sda_h = give_ack ? 1'b0 : 1'b1; qw();
    scl_h = 1'b1; qw(); qw();
    scl_h = 1'b0; qw();
    sda_h = 1'b1;
  endtask

  task automatic check_outputs(input string req);
    chk({req, " cfg"},     cfg_o,        exp_q[0]);
    chk({req, " chan_en"}, chan_en_o,    exp_q[1]);
    chk({req, " stop_sel"},stop_sel_o,   exp_q[2]);
    chk({req, " spare"},   spare_o,      exp_q[3]);
    chk({req, " rev"},     rev_vendor_o, exp_q[4]);
    chk({req, " dev_id"},  dev_id_o,     exp_q[5]);
    chk({req, " rd_len"},  rd_len_o,     exp_q[6]);
  endtask

  // Read all indices 0..7 via the indexed read sequence (R5, R7)
  task automatic read_all(input string req);
    logic nak;
    logic [7:0] b;
    bus_start();
    send_byte(8'hDC, nak); chk({req, " R2 wr addr ack"}, {7'd0, nak}, 8'h00);
    send_byte(8'h00, nak); chk({req, " R3 index ack"}, {7'd0, nak}, 8'h00);
    bus_start();
    send_byte(8'hDD, nak); chk({req, " R2 rd addr ack"}, {7'd0, nak}, 8'h00);
    recv_byte(1'b1, b);    chk({req, " R5 length byte"}, b, exp_q[6]);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i < 7, b);
      chk($sformatf("%s R5 R7 read idx %0d", req, i), b, exp_q[i]);
    end
    bus_stop();
    chk({req, " R8 released after nack"}, {7'd0, sda_pd_o}, 8'h00);
  endtask

  task automatic block_write(input int n, input int x, input int seed, output logic any_nak);
    logic nak;
    logic [7:0] d;
    any_nak = 1'b0;
    bus_start();
    send_byte(8'hDC, nak);      any_nak |= nak;
    send_byte(8'(n), nak);      any_nak |= nak;
    send_byte(8'(x), nak);      any_nak |= nak;
    for (int k = 0; k < x; k++) begin
      d = 8'((n * 37 + k * 91 + x * 13 + seed) & 255);
      send_byte(d, nak);        any_nak |= nak;
      model_write(n + k, d);
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R3 actual=timeout expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic nak, any;
    logic [7:0] b;
    exp_q[0] = 8'h07; exp_q[1] = 8'hFF; exp_q[2] = 8'h00; exp_q[3] = 8'h00;
    exp_q[4] = 8'h01; exp_q[5] = 8'h08; exp_q[6] = 8'h05; exp_q[7] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R1: reset contents
    check_outputs("R1 reset");
    chk("R1 sda_pd idle", {7'd0, sda_pd_o}, 8'h00);
    read_all("R1 R6 reset readback");

    // R3/R4/R7 sweep over start index and count, with readback of every index
    for (int n = 0; n < 8; n++) begin
      for (int x = 0; x < 4; x++) begin
        block_write(n, x, 5, any);
        chk($sformatf("R3 acks n=%0d x=%0d", n, x), {7'd0, any}, 8'h00);
        chk("R8 released after stop", {7'd0, sda_pd_o}, 8'h00);
        check_outputs("R3 sweep");
        read_all("R5 sweep");
      end
    end

    // R6: read-only identity byte and reserved configuration bits
    block_write(0, 1, 250, any);
    bus_start();
    send_byte(8'hDC, nak); send_byte(8'h00, nak); send_byte(8'h02, nak);
    send_byte(8'hFF, nak); model_write(0, 8'hFF);
    send_byte(8'hFF, nak); model_write(1, 8'hFF);
    bus_stop();
    chk("R6 cfg reserved bits", cfg_o, 8'hC7);
    bus_start();
    send_byte(8'hDC, nak); send_byte(8'h04, nak); send_byte(8'h01, nak);
    send_byte(8'hA5, nak);
    chk("R6 write to fixed byte acked", {7'd0, nak}, 8'h00);
    bus_stop();
    chk("R6 fixed byte", rev_vendor_o, 8'h01);

    // R4: bytes past the count are acked and discarded
    bus_start();
    send_byte(8'hDC, nak); send_byte(8'h02, nak); send_byte(8'h01, nak);
    send_byte(8'h3C, nak); model_write(2, 8'h3C);
    send_byte(8'h99, nak);
    chk("R4 extra byte acked", {7'd0, nak}, 8'h00);
    bus_stop();
    chk("R4 stored byte", stop_sel_o, 8'h3C);
    chk("R4 next byte untouched", spare_o, exp_q[3]);

    // R2: foreign address is not acknowledged and its bytes are ignored
    bus_start();
    send_byte(8'hA0, nak); chk("R2 foreign addr nack", {7'd0, nak}, 8'h01);
    send_byte(8'h01, nak); chk("R2 ignored byte nack", {7'd0, nak}, 8'h01);
    send_byte(8'h01, nak);
    send_byte(8'h55, nak);
    bus_stop();
    check_outputs("R2 foreign write");

    // R7: read starting beyond the last index
    bus_start();
    send_byte(8'hDC, nak); send_byte(8'h09, nak);
    bus_start();
    send_byte(8'hDD, nak);
    recv_byte(1'b1, b); chk("R7 length byte", b, exp_q[6]);
    recv_byte(1'b0, b); chk("R7 read beyond range", b, 8'h00);
    bus_stop();

    // R9: stop inside a data byte aborts the store
    bus_start();
    send_byte(8'hDC, nak); send_byte(8'h01, nak); send_byte(8'h01, nak);
    send_bits(8'h00, 4);
    bus_stop();
    chk("R9 stop abort", chan_en_o, exp_q[1]);
    chk("R9 released after abort", {7'd0, sda_pd_o}, 8'h00);

    // R9: start inside a data byte, index kept for the read
    bus_start();
    send_byte(8'hDC, nak); send_byte(8'h02, nak); send_byte(8'h02, nak);
    send_bits(8'h00, 3);
    bus_start();
    send_byte(8'hDD, nak); chk("R9 restart addr ack", {7'd0, nak}, 8'h00);
    recv_byte(1'b1, b);    chk("R9 length after restart", b, exp_q[6]);
    recv_byte(1'b0, b);    chk("R9 index kept", b, exp_q[2]);
    bus_stop();
    chk("R9 no partial store", stop_sel_o, exp_q[2]);

    // R8: slave never pulled SDA during host-driven data bits
    chk("R8 no pull during host bits", {7'd0, pd_bad}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule